// File: doc/BRIEF.md
# Receive Hunt and Purge Controller

This block sits between a serial receiver's character assembler and the software-visible receive storage. Each complete character goes first into a one-entry holding register and then into a 32-entry main receive FIFO. A four-entry side FIFO records the receive character counter value at every end of frame. Software issues five-bit command codes. One command forces the receiver back into hunt. Three commands purge the receive structures. A purge empties the holding register as well as the FIFO, so a stale character cannot later appear as a one-character frame. A purge also reloads the character counter from the count-limit input.

The block is built around a three-state machine. `ST_HUNT` is the reset state; characters are ignored here and the block waits for sync. `ST_RECV` accepts characters. `ST_ABT_WAIT` is entered on an abort strobe. Four transitions are named. `ST_HUNT` to `ST_RECV` happens on `sync_det`. `ST_RECV` to `ST_ABT_WAIT` happens on `char_abort`. `ST_ABT_WAIT` to `ST_HUNT` happens once the holding register is empty, and at that point the abort flag is set. Every state goes to `ST_HUNT` on the enter-hunt command. The abort flag is therefore raised only after the last character before the abort has landed in the FIFO.

Top module: `rxq_hunt_purge_ctl`

## Requirements
- R1: After reset the block is in hunt (`hunt`=1), both FIFOs are empty, `char_cnt`=0, and `abort_flag`, `cnt_ovf` and `asm_flush` are 0.
- R2: In hunt, `char_vld` is ignored and `sync_det` moves the block to receive (`hunt`=0). In receive, each strobed character is captured into the holding register. It moves into the main FIFO on the next clock edge if the FIFO is not full, and characters leave the FIFO in arrival order. Each entry is {eof, data}, with the eof flag at bit 8 and the data at bits 7:0.
- R3: Code 5'b00011 (enter hunt) forces `hunt`=1 from any state. It pulses `asm_flush` for exactly one cycle so the assembler drops its partial character, and it clears `abort_flag`.
- R4: Codes 5'b01001 and 5'b01011 (bits 4:2 = 010 with bit 0, the receive select, set) empty the main FIFO and the holding register. They leave the count FIFO untouched. Code 5'b01010 (transmit select only) and every undefined code leave the receive side unchanged.
- R5: Code 5'b11001 empties the main FIFO, the count FIFO and the holding register together, and it clears `cnt_ovf`.
- R6: Every receive purge (01001, 01011, 11001) makes `char_cnt` equal to `cnt_limit` on the following cycle.
- R7: When a purge coincides with a holding-register transfer or with a character capture, the purge wins. The character never reaches the FIFO.
- R8: Each character written into the main FIFO decrements `char_cnt`, saturating at 0. When that character carries eof, the decremented value is pushed into the count FIFO and `char_cnt` is reloaded from `cnt_limit`.
- R9: After `char_abort` in receive, `abort_flag` rises only when the holding register is empty. This is at least one cycle after the last pending character has entered the main FIFO. At that point the block returns to hunt.
- R10: The count FIFO holds 4 entries. An end-of-frame push while it is full is dropped and sets the sticky `cnt_ovf`.
- R11: While the main FIFO is full, the holding register keeps its character. A further character that arrives while the holding register is occupied and not draining is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_det | input | 1 | Sync or flag found; leaves hunt |
| char_vld | input | 1 | Assembled character strobe |
| char_data | input | 8 | Assembled character |
| char_eof | input | 1 | Character ends a frame |
| char_abort | input | 1 | Abort or break detected |
| cmd_vld | input | 1 | Command strobe |
| cmd_code | input | 5 | Command code |
| cnt_limit | input | 16 | Character count limit |
| rx_pop | input | 1 | Pop main FIFO |
| rx_dout | output | 9 | Head entry {eof, data} |
| rx_empty | output | 1 | Main FIFO empty |
| rx_level | output | 6 | Main FIFO occupancy |
| cnt_pop | input | 1 | Pop count FIFO |
| cnt_dout | output | 16 | Head frame-end count |
| cnt_empty | output | 1 | Count FIFO empty |
| cnt_level | output | 3 | Count FIFO occupancy |
| char_cnt | output | 16 | Receive character counter |
| hunt | output | 1 | Block is in hunt |
| abort_flag | output | 1 | Abort/break status |
| cnt_ovf | output | 1 | Count FIFO overflow (sticky) |
| asm_flush | output | 1 | One-cycle discard request to the assembler |

## Verification
Two functions can fall in the same cycle. The first is a receive purge. The second is the holding register either draining into the FIFO or capturing a new character. The bench provokes the drain case by issuing a purge on the edge right after a capture, which is the edge where the transfer would occur. It provokes the capture case by raising a character strobe and a purge on the same edge. In both cases the purge must win: the main FIFO must stay empty over the following cycles, and the counter must show the reloaded limit. A second race is also exercised. An abort arrives while the FIFO is full and the holding register is occupied. The bench confirms that the flag stays low until one pop has let the held character in, and that the held character is the last entry drained.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic [1:0] {
        ST_HUNT,
        ST_RECV,
        ST_ABT_WAIT
    } rx_state_e;

    localparam logic [4:0] CMD_HUNT       = 5'b00011;
    localparam logic [4:0] CMD_PURGE_RX   = 5'b01001;
    localparam logic [4:0] CMD_PURGE_TX   = 5'b01010;
    localparam logic [4:0] CMD_PURGE_RXTX = 5'b01011;
    localparam logic [4:0] CMD_PURGE_ALL  = 5'b11001;
endpackage

// File: rtl/rxq_cmd_dec.sv
module rxq_cmd_dec
    import rxq_pkg::*;
(
    input  logic       cmd_vld,
    input  logic [4:0] cmd_code,
    output logic       hunt_cmd,
    output logic       purge_rx,
    output logic       purge_all
);
    logic fifo_family;

    always_comb begin
        // purge-FIFO family: bits 4:2 = 010, bit0 selects receive side
        fifo_family = (cmd_code[4:2] == 3'b010) && cmd_code[0];
        hunt_cmd    = cmd_vld && (cmd_code == CMD_HUNT);
        purge_all   = cmd_vld && (cmd_code == CMD_PURGE_ALL);
        purge_rx    = (cmd_vld && fifo_family) || purge_all;
    end
endmodule

// File: rtl/rxq_sync_fifo.sv
module rxq_sync_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     push,
    input  logic [W-1:0]             din,
    input  logic                     pop,
    output logic [W-1:0]             dout,
    output logic                     empty,
    output logic                     full,
    output logic [$clog2(DEPTH):0]   level
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign empty   = (level == '0);
    assign full    = (level == (AW+1)'(DEPTH));
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (do_pop && !do_push) level <= level - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end
endmodule

// File: rtl/rxq_hunt_purge_ctl.sv
module rxq_hunt_purge_ctl
    import rxq_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int RX_DEPTH = 32,
    parameter int CF_DEPTH = 4,
    parameter int CNT_W    = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sync_det,
    input  logic                        char_vld,
    input  logic [DATA_W-1:0]           char_data,
    input  logic                        char_eof,
    input  logic                        char_abort,
    input  logic                        cmd_vld,
    input  logic [4:0]                  cmd_code,
    input  logic [CNT_W-1:0]            cnt_limit,
    input  logic                        rx_pop,
    output logic [DATA_W:0]             rx_dout,
    output logic                        rx_empty,
    output logic [$clog2(RX_DEPTH):0]   rx_level,
    input  logic                        cnt_pop,
    output logic [CNT_W-1:0]            cnt_dout,
    output logic                        cnt_empty,
    output logic [$clog2(CF_DEPTH):0]   cnt_level,
    output logic [CNT_W-1:0]            char_cnt,
    output logic                        hunt,
    output logic                        abort_flag,
    output logic                        cnt_ovf,
    output logic                        asm_flush
);
    localparam int ENT_W = DATA_W + 1;

    rx_state_e           state, state_nx;
    logic                hunt_cmd, purge_rx, purge_all;
    logic                hold_v;
    logic [ENT_W-1:0]    hold_q;
    logic                rx_full, cnt_full;
    logic                xfer, cap, cnt_push;
    logic [CNT_W-1:0]    cnt_dec;

    rxq_cmd_dec u_dec (
        .cmd_vld   (cmd_vld),
        .cmd_code  (cmd_code),
        .hunt_cmd  (hunt_cmd),
        .purge_rx  (purge_rx),
        .purge_all (purge_all)
    );

    // holding-register movement; a purge overrides both directions
    assign xfer     = hold_v && !rx_full && !purge_rx;
    assign cap      = char_vld && (state == ST_RECV) && !purge_rx && (!hold_v || xfer);
    assign cnt_push = xfer && hold_q[DATA_W];
    assign cnt_dec  = (char_cnt == '0) ? '0 : char_cnt - 1'b1;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HUNT:     if (sync_det)   state_nx = ST_RECV;
            ST_RECV:     if (char_abort) state_nx = ST_ABT_WAIT;
            ST_ABT_WAIT: if (!hold_v)    state_nx = ST_HUNT;
            default:                     state_nx = ST_HUNT;
        endcase
        if (hunt_cmd) state_nx = ST_HUNT;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nx;
    end

    // registered outputs driven by the state machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            asm_flush  <= 1'b0;
            abort_flag <= 1'b0;
        end else begin
            asm_flush <= hunt_cmd;
            if (hunt_cmd)
                abort_flag <= 1'b0;
            else if (state == ST_ABT_WAIT && !hold_v)
                abort_flag <= 1'b1;
        end
    end

    assign hunt = (state == ST_HUNT);

    // holding register, character counter, overflow flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_v   <= 1'b0;
            hold_q   <= '0;
            char_cnt <= '0;
            cnt_ovf  <= 1'b0;
        end else begin
            if (purge_rx)  hold_v <= 1'b0;
            else if (cap)  hold_v <= 1'b1;
            else if (xfer) hold_v <= 1'b0;
            if (cap) hold_q <= {char_eof, char_data};

            if (purge_rx)  char_cnt <= cnt_limit;
            else if (xfer) char_cnt <= hold_q[DATA_W] ? cnt_limit : cnt_dec;

            if (purge_all)                cnt_ovf <= 1'b0;
            else if (cnt_push && cnt_full) cnt_ovf <= 1'b1;
        end
    end

    rxq_sync_fifo #(.W(ENT_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (purge_rx),
        .push  (xfer),
        .din   (hold_q),
        .pop   (rx_pop),
        .dout  (rx_dout),
        .empty (rx_empty),
        .full  (rx_full),
        .level (rx_level)
    );

    rxq_sync_fifo #(.W(CNT_W), .DEPTH(CF_DEPTH)) u_cnt_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (purge_all),
        .push  (cnt_push),
        .din   (cnt_dec),
        .pop   (cnt_pop),
        .dout  (cnt_dout),
        .empty (cnt_empty),
        .full  (cnt_full),
        .level (cnt_level)
    );
endmodule

module rxq_hunt_purge_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hunt_cmd,
    input logic             purge_rx,
    input logic             purge_all,
    input logic             hold_v,
    input logic             cnt_push,
    input logic             cnt_full,
    input logic             rx_empty,
    input logic             cnt_empty,
    input logic             hunt,
    input logic             abort_flag,
    input logic             cnt_ovf,
    input logic             asm_flush,
    input logic [CNT_W-1:0] char_cnt,
    input logic [CNT_W-1:0] cnt_limit
);
    AST_HUNT_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        hunt_cmd |=> hunt && asm_flush && !abort_flag);                    // R3
    AST_PURGE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        purge_rx |=> rx_empty && !hold_v);                                  // R7
    AST_PURGE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        purge_rx |=> char_cnt == $past(cnt_limit));                         // R6
    AST_FULL_PURGE: assert property (@(posedge clk) disable iff (!rst_n)
        purge_all |=> cnt_empty && !cnt_ovf);                               // R5
    AST_ABORT_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abort_flag) |-> !hold_v && $past(!hold_v));                   // R9
    AST_NO_OVERFLOW_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_push && cnt_full |=> cnt_ovf);                                  // R10
endmodule

bind rxq_hunt_purge_ctl rxq_hunt_purge_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hunt_cmd   (hunt_cmd),
    .purge_rx   (purge_rx),
    .purge_all  (purge_all),
    .hold_v     (hold_v),
    .cnt_push   (cnt_push),
    .cnt_full   (cnt_full),
    .rx_empty   (rx_empty),
    .cnt_empty  (cnt_empty),
    .hunt       (hunt),
    .abort_flag (abort_flag),
    .cnt_ovf    (cnt_ovf),
    .asm_flush  (asm_flush),
    .char_cnt   (char_cnt),
    .cnt_limit  (cnt_limit)
);

// File: tb/rxq_hunt_purge_ctl_tb_top.sv
module rxq_hunt_purge_ctl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_det = 0, char_vld = 0, char_eof = 0, char_abort = 0;
    logic [7:0]  char_data = '0;
    logic        cmd_vld = 0;
    logic [4:0]  cmd_code = '0;
    logic [15:0] cnt_limit = '0;
    logic        rx_pop = 0, cnt_pop = 0;
    logic [8:0]  rx_dout;
    logic        rx_empty, cnt_empty, hunt, abort_flag, cnt_ovf, asm_flush;
    logic [5:0]  rx_level;
    logic [2:0]  cnt_level;
    logic [15:0] cnt_dout, char_cnt;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    rxq_hunt_purge_ctl dut_i (.*);

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] d, input logic e);
        char_vld = 1; char_data = d; char_eof = e;
        tick();
        char_vld = 0; char_eof = 0;
    endtask

    task automatic do_cmd(input logic [4:0] c);
        cmd_vld = 1; cmd_code = c;
        tick();
        cmd_vld = 0;
    endtask

    task automatic go_sync();
        sync_det = 1; tick(); sync_det = 0;
    endtask

    task automatic pop_rx_chk(input logic [8:0] exp, input string req);
        chk(req, "rx_dout", rx_dout, exp);
        rx_pop = 1; tick(); rx_pop = 0;
    endtask

    task automatic pop_cnt_chk(input logic [15:0] exp, input string req);
        chk(req, "cnt_dout", cnt_dout, exp);
        cnt_pop = 1; tick(); cnt_pop = 0;
    endtask

    task automatic t_reset();
        chk("R1", "hunt", hunt, 1);
        chk("R1", "rx_empty", rx_empty, 1);
        chk("R1", "cnt_empty", cnt_empty, 1);
        chk("R1", "char_cnt", char_cnt, 0);
        chk("R1", "abort_flag", abort_flag, 0);
        chk("R1", "cnt_ovf", cnt_ovf, 0);
        chk("R1", "asm_flush", asm_flush, 0);
    endtask

    task automatic t_basic();
        cnt_limit = 16'd100;
        do_cmd(5'b01001);
        chk("R6", "char_cnt reload", char_cnt, 100);
        send_char(8'h11, 0);
        tick(2);
        chk("R2", "ignored in hunt", rx_empty, 1);
        go_sync();
        chk("R2", "hunt after sync", hunt, 0);
        send_char(8'hA5, 0);
        send_char(8'h3C, 0);
        tick();
        chk("R8", "char_cnt mid frame", char_cnt, 98);
        send_char(8'h7E, 1);
        tick();
        chk("R2", "rx_level", rx_level, 3);
        chk("R8", "cnt_dout", cnt_dout, 97);
        chk("R8", "char_cnt reload at eof", char_cnt, 100);
        pop_rx_chk(9'h0A5, "R2");
        pop_rx_chk(9'h03C, "R2");
        pop_rx_chk(9'h17E, "R2");
        pop_cnt_chk(16'd97, "R8");
        chk("R8", "cnt_empty", cnt_empty, 1);
    endtask

    task automatic t_hunt();
        do_cmd(5'b00011);
        chk("R3", "hunt", hunt, 1);
        chk("R3", "asm_flush pulse", asm_flush, 1);
        tick();
        chk("R3", "asm_flush one cycle", asm_flush, 0);
        go_sync();
    endtask

    task automatic t_purge_sel();
        send_char(8'h21, 0);
        send_char(8'h22, 1);
        tick();
        chk("R4", "level before", rx_level, 2);
        do_cmd(5'b01010);
        chk("R4", "tx-only keeps rx", rx_level, 2);
        do_cmd(5'b00111);
        chk("R4", "undefined code ignored", rx_level, 2);
        cnt_limit = 16'd55;
        do_cmd(5'b01011);
        chk("R4", "rx+tx purge empties", rx_empty, 1);
        chk("R4", "count fifo kept", cnt_empty, 0);
        chk("R6", "reload 55", char_cnt, 55);
        do_cmd(5'b11001);
        chk("R5", "count fifo emptied", cnt_empty, 1);
    endtask

    task automatic t_collision();
        cnt_limit = 16'd40;
        send_char(8'h31, 0);
        do_cmd(5'b01001);
        tick(2);
        chk("R7", "purge beats transfer", rx_empty, 1);
        chk("R7", "char_cnt", char_cnt, 40);
        char_vld = 1; char_data = 8'h32; cmd_vld = 1; cmd_code = 5'b01001;
        tick();
        char_vld = 0; cmd_vld = 0;
        tick(2);
        chk("R7", "purge beats capture", rx_empty, 1);
    endtask

    task automatic t_ovf();
        cnt_limit = 16'd10;
        do_cmd(5'b11001);
        for (int i = 0; i < 5; i++) send_char(8'(i), 1);
        tick();
        chk("R10", "cnt_ovf", cnt_ovf, 1);
        chk("R10", "cnt_level", cnt_level, 4);
        chk("R10", "rx_level", rx_level, 5);
        for (int i = 0; i < 4; i++) pop_cnt_chk(16'd9, "R10");
        chk("R10", "cnt_empty after 4", cnt_empty, 1);
        chk("R10", "ovf sticky", cnt_ovf, 1);
        do_cmd(5'b11001);
        chk("R5", "ovf cleared", cnt_ovf, 0);
        chk("R5", "rx emptied", rx_empty, 1);
    endtask

    task automatic t_abort();
        for (int i = 0; i < 32; i++) send_char(8'(i), 0);
        tick();
        chk("R11", "full", rx_level, 32);
        send_char(8'hEE, 0);
        tick();
        chk("R11", "stall keeps level", rx_level, 32);
        send_char(8'hDD, 0);
        char_abort = 1; tick(); char_abort = 0;
        tick(3);
        chk("R9", "flag held while pending", abort_flag, 0);
        chk("R9", "not hunting yet", hunt, 0);
        pop_rx_chk(9'h000, "R9");
        chk("R9", "flag low at pop", abort_flag, 0);
        tick();
        chk("R9", "flag low at transfer", abort_flag, 0);
        chk("R9", "held char landed", rx_level, 32);
        tick();
        chk("R9", "flag set", abort_flag, 1);
        chk("R9", "back to hunt", hunt, 1);
        for (int i = 1; i < 32; i++) pop_rx_chk(9'(i), "R11");
        pop_rx_chk(9'h0EE, "R11");
        chk("R11", "second char dropped", rx_empty, 1);
        do_cmd(5'b00011);
        chk("R3", "hunt clears flag", abort_flag, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick();
        t_reset();
        t_basic();
        t_hunt();
        t_purge_sel();
        t_collision();
        t_ovf();
        t_abort();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule